// File: doc/BRIEF.md
# Complementary output short detector

This block guards three complementary drive pairs, such as the high-side and low-side gates of a three-phase bridge. Each pair should never have both lines low at once. The six pin levels are brought into the clock domain through a synchronizer. Once comparison is enabled, the block latches a sticky short flag as soon as any pair is seen low-low.

A second enable bit decides whether a latched short is acted on. When both enables are set and the flag is up, the block takes all six pins to high impedance and raises an interrupt line. The pins stay released until software clears the flag. Software clears it by reading the flag as 1 and then writing 0 to it.

Software reaches the block through a single 16-bit register on a plain select/write/read bus. There is no streaming data path, so no valid/ready handshake is used. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `short_guard`

## Requirements
- R1: After reset the register reads 0x0000, `pin_oe` is all ones (pins driven), and `hiz_req` and `irq` are 0.
- R2: Register bits 14 to 10 and 7 to 0 always read 0, and writing 1s to them changes nothing.
- R3: Bit 9 (compare enable) and bit 8 (request enable) are read/write. A write takes effect at the clock edge of the write cycle.
- R4: With compare enable at 1, the flag in bit 15 sets when, after two synchronizer stages, some pair has both its `drv_hi[i]` and `drv_lo[i]` low on one sampled cycle. A pair that is low-low for one input sample sets the flag on the third rising edge after the change. With compare enable at 0 nothing sets the flag. A pair with only one line low never sets it.
- R5: A write that sets compare enable while a synchronized pair is already low-low sets the flag on that same edge.
- R6: The flag clears only when a write with bit 15 = 0 follows a read that returned the flag as 1. A clearing write without such a prior read has no effect, and writing 1 to bit 15 has no effect.
- R7: When a clearing write and a set condition occur on the same edge, the flag stays set.
- R8: `hiz_req` and `irq` are 1 exactly when the flag, compare enable and request enable are all 1. With request enable at 0 no request is made even though the flag is set.
- R9: `pin_oe` is all zeros (high impedance) while `hiz_req` is 1. It returns to all ones on the edge at which the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe (with select) |
| bus_rd | input | 1 | Read strobe (with select); marks the flag as observed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register contents |
| drv_hi | input | 3 | Level of the high-side line of each pair |
| drv_lo | input | 3 | Level of the low-side line of each pair |
| pin_oe | output | 6 | Output enable for the six pins, 1 = driven |
| hiz_req | output | 1 | High-impedance request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those that need edge-exact alignment between a bus write and a synchronized pin sample. Two cases stand out. In the first, compare enable is written while a pair is already low-low at the synchronizer output. In the second, a clearing write lands on the same edge as a fresh short. The bench holds a pair low across several samples so the condition is present at the synchronizer output, then issues the write or the read-then-clear sequence. A behavioural model, which keeps the pin samples in a queue, predicts every edge and is compared with the outputs on every clock.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int REG_W      = 16;
  localparam int FLAG_BIT   = 15;
  localparam int CMP_EN_BIT = 9;
  localparam int REQ_EN_BIT = 8;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int          W      = 6,
  parameter int          STAGES = 2,
  parameter logic [0:0]  RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= {W{RST_V}};
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sg_pair_cmp.sv
module sg_pair_cmp #(
  parameter int PAIRS = 3
) (
  input  logic [PAIRS-1:0] hi,
  input  logic [PAIRS-1:0] lo,
  output logic             any_short
);
  logic [PAIRS-1:0] both_low;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign both_low[p] = ~hi[p] & ~lo[p];
    end
  endgenerate

  assign any_short = |both_low;
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             short_now,
  output logic             flag,
  output logic             cmp_en,
  output logic             req_en
);
  logic armed, armed_n, flag_n, cmp_en_n, req_en_n, set_c, clr_c;

  always_comb begin
    cmp_en_n = wr_hit ? wdata[CMP_EN_BIT] : cmp_en;
    req_en_n = wr_hit ? wdata[REQ_EN_BIT] : req_en;
    set_c    = cmp_en_n & short_now;
    clr_c    = wr_hit & ~wdata[FLAG_BIT] & armed & flag;
    flag_n   = set_c | (flag & ~clr_c);
    if (!flag_n)                          armed_n = 1'b0;
    else if (rd_hit && flag)              armed_n = 1'b1;
    else if (wr_hit && !wdata[FLAG_BIT])  armed_n = 1'b0;
    else                                  armed_n = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      armed  <= 1'b0;
      cmp_en <= 1'b0;
      req_en <= 1'b0;
    end else begin
      flag   <= flag_n;
      armed  <= armed_n;
      cmp_en <= cmp_en_n;
      req_en <= req_en_n;
    end
  end
endmodule

// File: rtl/short_guard.sv
module short_guard
  import sg_pkg::*;
#(
  parameter int PAIRS       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [PAIRS-1:0]   drv_hi,
  input  logic [PAIRS-1:0]   drv_lo,
  output logic [2*PAIRS-1:0] pin_oe,
  output logic               hiz_req,
  output logic               irq
);
  localparam int PINS = 2 * PAIRS;

  logic [PINS-1:0] pins_s;
  logic            short_now, flag, cmp_en, req_en;
  logic            unused_wbits;

  assign unused_wbits = ^{bus_wdata[14:10], bus_wdata[7:0]};

  sg_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({drv_hi, drv_lo}), .q(pins_s)
  );

  sg_pair_cmp #(.PAIRS(PAIRS)) u_cmp (
    .hi(pins_s[PINS-1:PAIRS]), .lo(pins_s[PAIRS-1:0]), .any_short(short_now)
  );

  sg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(bus_sel & bus_wr), .rd_hit(bus_sel & bus_rd),
    .wdata(bus_wdata), .short_now(short_now),
    .flag(flag), .cmp_en(cmp_en), .req_en(req_en)
  );

  always_comb begin
    bus_rdata             = '0;
    bus_rdata[FLAG_BIT]   = flag;
    bus_rdata[CMP_EN_BIT] = cmp_en;
    bus_rdata[REQ_EN_BIT] = req_en;
  end

  assign hiz_req = flag & cmp_en & req_en;
  assign irq     = hiz_req;
  assign pin_oe  = {PINS{~hiz_req}};
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [5:0]  pin_oe,
  input logic        hiz_req,
  input logic        irq
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[14:10] == 5'd0 && bus_rdata[7:0] == 8'd0); // R2
  AST_REQ_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |-> (bus_rdata[15] && bus_rdata[9] && bus_rdata[8])); // R8
  AST_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq == hiz_req); // R8
  AST_RELEASE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[15] |-> pin_oe == 6'h3F); // R9
  AST_HIZ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |-> pin_oe == 6'h00); // R9
  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rdata[15]) |-> $past(bus_sel && bus_wr && !bus_wdata[15])); // R6
  AST_SET_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[15]) |-> bus_rdata[9]); // R4
endmodule

bind short_guard sg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
  .hiz_req(hiz_req), .irq(irq)
);

// File: tb/tb_short_guard.sv
`timescale 1ns/1ps
module tb_short_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  drv_hi = 3'b111, drv_lo = 3'b000;
  logic [5:0]  pin_oe;
  logic        hiz_req, irq;

  int n_cmp = 0, n_bad = 0;
  string req_tag = "R1";

  always #2.5 clk = ~clk;

  short_guard dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_hi(drv_hi), .drv_lo(drv_lo),
    .pin_oe(pin_oe), .hiz_req(hiz_req), .irq(irq)
  );

  // behavioural reference model
  logic [5:0] samples[$];
  bit m_flag, m_armed, m_cmp, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samples.delete();
      m_flag = 0; m_armed = 0; m_cmp = 0; m_req = 0;
    end else begin
      bit wr, rd, short, nc, nr, nf, clr;
      logic [5:0] synced;
      wr = bus_sel && bus_wr;
      rd = bus_sel && bus_rd;
      synced = (samples.size() == 2) ? samples[0] : 6'h3F;
      short = 0;
      for (int i = 0; i < 3; i++)
        if (synced[3+i] == 0 && synced[i] == 0) short = 1;
      nc = wr ? bus_wdata[9] : m_cmp;
      nr = wr ? bus_wdata[8] : m_req;
      clr = wr && !bus_wdata[15] && m_armed && m_flag;
      nf = (nc && short) ? 1 : (clr ? 0 : m_flag);
      if (!nf) m_armed = 0;
      else if (rd && m_flag) m_armed = 1;
      else if (wr && !bus_wdata[15]) m_armed = 0;
      m_flag = nf; m_cmp = nc; m_req = nr;
      samples.push_back({drv_hi, drv_lo});
      if (samples.size() > 2) void'(samples.pop_front());
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) compare();
  end

  task automatic compare();
    logic [15:0] e_rd;
    bit e_req;
    e_rd = 16'h0;
    e_rd[15] = m_flag; e_rd[9] = m_cmp; e_rd[8] = m_req;
    e_req = m_flag && m_cmp && m_req;
    n_cmp++;
    if (bus_rdata !== e_rd || hiz_req !== e_req || irq !== e_req ||
        pin_oe !== (e_req ? 6'h00 : 6'h3F)) begin
      n_bad++;
      $display("FAIL %s: rdata=%h hiz=%b irq=%b oe=%h expected rdata=%h hiz=%b irq=%b oe=%h",
               req_tag, bus_rdata, hiz_req, irq, pin_oe, e_rd, e_req, e_req,
               e_req ? 6'h00 : 6'h3F);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [15:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd_reg();
    @(negedge clk); bus_sel = 1; bus_rd = 1;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic short_pair(int p, int cycles);
    @(negedge clk); drv_hi[p] = 0; drv_lo[p] = 0;
    repeat (cycles) @(negedge clk);
    drv_hi[p] = 1; drv_lo[p] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req_tag = "R1"; idle(3);
    if (bus_rdata !== 16'h0 || pin_oe !== 6'h3F || irq !== 0) begin
      n_bad++; $display("FAIL R1: rdata=%h oe=%h irq=%b expected 0000 3f 0", bus_rdata, pin_oe, irq);
    end
    n_cmp++;
    req_tag = "R2/R3"; wr_reg(16'hFFFF); idle(2);   // flag bit write-1 ignored, reserved zero
    wr_reg(16'h0000); idle(2);
    req_tag = "R4"; short_pair(0, 3); idle(5);      // compare disabled: no set
    drv_lo[1] = 1; drv_hi[1] = 0; idle(4);          // one line low only
    drv_hi[1] = 1; drv_lo[1] = 0;
    wr_reg(16'h0200); short_pair(1, 1); idle(5);    // single sample sets flag
    req_tag = "R8"; idle(2);                        // request enable 0: no hiz
    req_tag = "R6"; wr_reg(16'h0200); idle(2);      // clear without read: no effect
    rd_reg(); wr_reg(16'h8200); idle(2);            // write 1: no effect
    rd_reg(); wr_reg(16'h0200); idle(3);            // proper clear
    req_tag = "R8/R9"; wr_reg(16'h0300); short_pair(2, 1); idle(5);
    req_tag = "R7"; @(negedge clk); drv_hi[2] = 0; drv_lo[2] = 0; idle(3);
    rd_reg(); wr_reg(16'h0300); idle(2);            // set wins
    drv_hi[2] = 1; idle(4);
    req_tag = "R9"; rd_reg(); wr_reg(16'h0300); idle(3);
    req_tag = "R5"; wr_reg(16'h0000); rd_reg(); idle(1);
    @(negedge clk); drv_hi[0] = 0; drv_lo[0] = 0; idle(4);
    wr_reg(16'h0300); idle(2);                      // enable while low-low
    drv_hi[0] = 1; idle(4);
    req_tag = "R1"; @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule